// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Overlay

This block lays a 64x64 monochrome cursor over a stream of 32-bit display pixels. Each cursor pixel is described by two bits, one from a mask plane and one from a pattern plane. The pair selects whether the screen pixel is left alone, inverted, or replaced by one of two programmable 24-bit colours. The block holds the cursor position, the line-data offset and the two colours as registers. A position write carries a lock flag that freezes position and offset changes until it is cleared.

The video timing side pulses `line_start` during horizontal blanking and gives the number of the coming line. A small fetch state machine decides whether the cursor touches that line. If it does, the machine reads the line's 16 bytes through a byte-wide memory read port into a line buffer before active video starts. During active video every valid pixel passes through a one-cycle pipeline stage. That stage either copies it or changes it. The cursor is cut off at the horizontal display width and never spills onto the next line.

The fetch machine has four states. IDLE waits for `line_start`. EVAL tests the captured line against the enable, the vertical window and the vertical display end. FETCH issues the 16 byte reads. DRAIN collects the last returning bytes. The transitions are as follows. `line_start` from any state goes to EVAL. EVAL goes to FETCH on a hit and to IDLE on a miss. FETCH goes to DRAIN after the sixteenth request. DRAIN goes to IDLE on the sixteenth returned byte, and that transition marks the buffer valid.

Top module: `curs_overlay`

## Requirements
- R1: In a line record, bytes 0-7 are the mask plane and bytes 8-15 are the pattern plane. Cursor column c takes bit (7 - c mod 8) of byte c/8 in each plane, so the most significant bit is the leftmost pixel.
- R2: Mask 1 with pattern 1 outputs the bitwise complement of the incoming pixel.
- R3: Mask 1 with pattern 0 passes the incoming pixel unchanged.
- R4: Mask 0 outputs {colour, 8'hFF}, using colour1 when the pattern bit is 1 and colour0 when it is 0.
- R5: A pixel is modified only when `cur_en` is 1, cursor_y <= scan_y < cursor_y + 64, and cursor_x <= scan_x < cursor_x + 64. Otherwise it passes unchanged.
- R6: Lines with scan_y greater than `vde` are never modified.
- R7: Pixels with scan_x >= `hdisp` are never modified.
- R8: `reg_sel` selects the register written by `reg_wdata`: 0 is position, 1 is offset, 2 is colour0 and 3 is colour1. Position takes X from bits 29:16 and Y from bits 11:0, and all other bits are ignored. Each colour keeps bits 23:0.
- R9: Bit 31 of a position write is the lock. While it is set, new position and offset values are held back. A position write with bit 31 clear applies the pending position and offset.
- R10: For a drawn line, exactly 16 reads are issued, at addresses base + offset + (scan_y - cursor_y)*16 + k for k = 0..15 in order. The offset has its low 4 bits forced to zero. A line that is not drawn issues no reads.
- R11: `pix_out_valid` and `pix_out` follow `pix_valid` and `pix_in` with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 position, 1 offset, 2 colour0, 3 colour1) |
| reg_wdata | input | 32 | Register write data |
| cur_en | input | 1 | Cursor enable |
| base_off | input | ADDR_W | Frame base byte address |
| vde | input | YW | Last visible line number |
| hdisp | input | XW | Horizontal display width in pixels |
| line_start | input | 1 | Pulse in blanking before a line |
| line_y | input | YW | Number of the coming line |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte read address |
| mem_rvalid | input | 1 | Read data valid, one cycle after request |
| mem_rdata | input | 8 | Read data byte |
| pix_valid | input | 1 | Incoming pixel valid |
| scan_x | input | XW | Column of incoming pixel |
| scan_y | input | YW | Line of incoming pixel |
| pix_in | input | 32 | Incoming pixel |
| pix_out | output | 32 | Resulting pixel |
| pix_out_valid | output | 1 | Resulting pixel valid |

## Verification
The hardest situation to reach is a position and offset update that is written while the lock is set and then released. The effect is only visible as the cursor staying in its old place for a whole line and moving after a later unlocking write. The bench writes a new position and offset with the lock set, draws a line where the old cursor must still show, then clears the lock and draws a line at the new place. Clipping at the right edge and at the vertical display end is reached by placing the cursor so that it straddles each limit. Random placements then mix in cases where the cursor hits and where it misses.

// File: rtl/curs_pkg.sv
package curs_pkg;
    localparam int PIX_W = 32;
    localparam int CLR_W = 24;

    typedef enum logic [1:0] {
        F_IDLE  = 2'd0,
        F_EVAL  = 2'd1,
        F_FETCH = 2'd2,
        F_DRAIN = 2'd3
    } fetch_st_t;

    typedef enum logic [1:0] {
        SEL_POS  = 2'd0,
        SEL_OFF  = 2'd1,
        SEL_CLR0 = 2'd2,
        SEL_CLR1 = 2'd3
    } reg_sel_t;
endpackage

// File: rtl/curs_regs.sv
module curs_regs
    import curs_pkg::*;
#(
    parameter int ADDR_W = 27,
    parameter int XW     = 14,
    parameter int YW     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [31:0]       wdata,
    output logic [XW-1:0]     cx,
    output logic [YW-1:0]     cy,
    output logic [ADDR_W-1:0] coff,
    output logic [CLR_W-1:0]  clr0,
    output logic [CLR_W-1:0]  clr1
);
    localparam int XLSB = 16;

    logic [XW-1:0]     pend_x;
    logic [YW-1:0]     pend_y;
    logic [ADDR_W-1:0] pend_off;
    logic              lock_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_x   <= '0;
            pend_y   <= '0;
            pend_off <= '0;
            lock_q   <= 1'b0;
            cx       <= '0;
            cy       <= '0;
            coff     <= '0;
            clr0     <= '0;
            clr1     <= '0;
        end else begin
            if (we) begin
                unique case (reg_sel_t'(sel))
                    SEL_POS: begin
                        pend_x <= wdata[XLSB +: XW];
                        pend_y <= wdata[YW-1:0];
                        lock_q <= wdata[31];
                    end
                    SEL_OFF:  pend_off <= {wdata[ADDR_W-1:4], 4'b0000};
                    SEL_CLR0: clr0     <= wdata[CLR_W-1:0];
                    SEL_CLR1: clr1     <= wdata[CLR_W-1:0];
                endcase
            end
            if (!lock_q) begin
                cx   <= pend_x;
                cy   <= pend_y;
                coff <= pend_off;
            end
        end
    end
endmodule

// File: rtl/curs_fetch.sv
module curs_fetch
    import curs_pkg::*;
#(
    parameter int ADDR_W  = 27,
    parameter int YW      = 12,
    parameter int CUR_DIM = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      line_start,
    input  logic [YW-1:0]             line_y,
    input  logic                      cur_en,
    input  logic [YW-1:0]             cy,
    input  logic [YW-1:0]             vde,
    input  logic [ADDR_W-1:0]         base_off,
    input  logic [ADDR_W-1:0]         coff,
    input  logic                      mem_rvalid,
    input  logic [7:0]                mem_rdata,
    output logic                      mem_req,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic                      line_ok,
    output logic [YW-1:0]             ly,
    output logic [2*CUR_DIM-1:0]      lbuf
);
    localparam int CW         = $clog2(CUR_DIM);
    localparam int LINE_BYTES = 2 * CUR_DIM / 8;
    localparam int BCW        = $clog2(LINE_BYTES);

    fetch_st_t      st_q, st_d;
    logic [CW-1:0]  rel_q;
    logic [BCW-1:0] qcnt, rcnt;
    logic [YW:0]    ydiff;
    logic           in_win;

    assign ydiff  = {1'b0, ly} - {1'b0, cy};
    assign in_win = cur_en && (ly >= cy) && (ydiff < (YW+1)'(CUR_DIM)) && (ly <= vde);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= F_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (line_start) begin
            st_d = F_EVAL;
        end else begin
            unique case (st_q)
                F_IDLE:  st_d = F_IDLE;
                F_EVAL:  st_d = in_win ? F_FETCH : F_IDLE;
                F_FETCH: st_d = (qcnt == BCW'(LINE_BYTES-1)) ? F_DRAIN : F_FETCH;
                F_DRAIN: st_d = (mem_rvalid && rcnt == BCW'(LINE_BYTES-1)) ? F_IDLE : F_DRAIN;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req = 1'b0;
        unique case (st_q)
            F_FETCH: mem_req = 1'b1;
            default: mem_req = 1'b0;
        endcase
    end

    assign mem_addr = base_off + coff + (ADDR_W'(rel_q) << BCW) + ADDR_W'(qcnt);

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ly      <= '0;
            rel_q   <= '0;
            qcnt    <= '0;
            rcnt    <= '0;
            line_ok <= 1'b0;
            lbuf    <= '0;
        end else if (line_start) begin
            ly      <= line_y;
            line_ok <= 1'b0;
            qcnt    <= '0;
            rcnt    <= '0;
        end else begin
            if (st_q == F_EVAL) rel_q <= ydiff[CW-1:0];
            if (st_q == F_FETCH) qcnt <= qcnt + 1'b1;
            if (mem_rvalid && (st_q == F_FETCH || st_q == F_DRAIN)) begin
                lbuf[8*rcnt +: 8] <= mem_rdata;
                rcnt <= rcnt + 1'b1;
            end
            if (st_q == F_DRAIN && st_d == F_IDLE) line_ok <= 1'b1;
        end
    end
endmodule

// File: rtl/curs_pix.sv
module curs_pix
    import curs_pkg::*;
#(
    parameter int XW      = 14,
    parameter int YW      = 12,
    parameter int CUR_DIM = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cur_en,
    input  logic                 line_ok,
    input  logic [YW-1:0]        ly,
    input  logic [XW-1:0]        cx,
    input  logic [CLR_W-1:0]     clr0,
    input  logic [CLR_W-1:0]     clr1,
    input  logic [YW-1:0]        vde,
    input  logic [XW-1:0]        hdisp,
    input  logic [2*CUR_DIM-1:0] lbuf,
    input  logic                 pix_valid,
    input  logic [XW-1:0]        scan_x,
    input  logic [YW-1:0]        scan_y,
    input  logic [PIX_W-1:0]     pix_in,
    output logic [PIX_W-1:0]     pix_out,
    output logic                 pix_out_valid
);
    localparam int CW = $clog2(CUR_DIM);

    logic [XW:0]      dx;
    logic [CW-1:0]    col, bidx;
    logic             hit, mbit, pbit;
    logic [PIX_W-1:0] pix_d;

    assign dx   = {1'b0, scan_x} - {1'b0, cx};
    assign col  = dx[CW-1:0];
    assign bidx = {col[CW-1:3], ~col[2:0]};
    assign mbit = lbuf[{1'b0, bidx}];
    assign pbit = lbuf[{1'b1, bidx}];
    assign hit  = cur_en && line_ok && (scan_y == ly) && (scan_y <= vde) &&
                  (scan_x >= cx) && (dx < (XW+1)'(CUR_DIM)) && (scan_x < hdisp);

    always_comb begin
        pix_d = pix_in;
        if (hit) begin
            unique case ({mbit, pbit})
                2'b11: pix_d = ~pix_in;
                2'b10: pix_d = pix_in;
                2'b01: pix_d = {clr1, 8'hFF};
                2'b00: pix_d = {clr0, 8'hFF};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_out       <= '0;
            pix_out_valid <= 1'b0;
        end else begin
            pix_out       <= pix_d;
            pix_out_valid <= pix_valid;
        end
    end
endmodule

// File: rtl/curs_overlay.sv
module curs_overlay
    import curs_pkg::*;
#(
    parameter int ADDR_W  = 27,
    parameter int XW      = 14,
    parameter int YW      = 12,
    parameter int CUR_DIM = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              cur_en,
    input  logic [ADDR_W-1:0] base_off,
    input  logic [YW-1:0]     vde,
    input  logic [XW-1:0]     hdisp,
    input  logic              line_start,
    input  logic [YW-1:0]     line_y,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    input  logic              pix_valid,
    input  logic [XW-1:0]     scan_x,
    input  logic [YW-1:0]     scan_y,
    input  logic [31:0]       pix_in,
    output logic [31:0]       pix_out,
    output logic              pix_out_valid
);
    logic [XW-1:0]        cx;
    logic [YW-1:0]        cy, ly;
    logic [ADDR_W-1:0]    coff;
    logic [CLR_W-1:0]     clr0, clr1;
    logic                 line_ok;
    logic [2*CUR_DIM-1:0] lbuf;

    curs_regs #(.ADDR_W(ADDR_W), .XW(XW), .YW(YW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .cx(cx), .cy(cy), .coff(coff), .clr0(clr0), .clr1(clr1)
    );

    curs_fetch #(.ADDR_W(ADDR_W), .YW(YW), .CUR_DIM(CUR_DIM)) u_fetch (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_y(line_y),
        .cur_en(cur_en), .cy(cy), .vde(vde), .base_off(base_off), .coff(coff),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .line_ok(line_ok), .ly(ly), .lbuf(lbuf)
    );

    curs_pix #(.XW(XW), .YW(YW), .CUR_DIM(CUR_DIM)) u_pix (
        .clk(clk), .rst_n(rst_n), .cur_en(cur_en), .line_ok(line_ok), .ly(ly),
        .cx(cx), .clr0(clr0), .clr1(clr1), .vde(vde), .hdisp(hdisp), .lbuf(lbuf),
        .pix_valid(pix_valid), .scan_x(scan_x), .scan_y(scan_y), .pix_in(pix_in),
        .pix_out(pix_out), .pix_out_valid(pix_out_valid)
    );
endmodule

// File: rtl/curs_overlay_chk.sv
module curs_overlay_chk #(
    parameter int ADDR_W  = 27,
    parameter int XW      = 14,
    parameter int YW      = 12,
    parameter int CUR_DIM = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cur_en,
    input logic [YW-1:0]     vde,
    input logic [XW-1:0]     hdisp,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              pix_valid,
    input logic [XW-1:0]     scan_x,
    input logic [YW-1:0]     scan_y,
    input logic [31:0]       pix_in,
    input logic [31:0]       pix_out,
    input logic              pix_out_valid
);
    localparam int LINE_BYTES = 2 * CUR_DIM / 8;

    int run_len;
    always_ff @(posedge clk) begin
        if (!rst_n)       run_len <= 0;
        else if (mem_req) run_len <= run_len + 1;
        else              run_len <= 0;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> pix_out_valid); // R11
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !pix_out_valid); // R11
    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !cur_en) |=> (pix_out == $past(pix_in))); // R5
    AST_BELOW_VDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && scan_y > vde) |=> (pix_out == $past(pix_in))); // R6
    AST_RIGHT_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && scan_x >= hdisp) |=> (pix_out == $past(pix_in))); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + 1'b1)); // R10
    AST_REQ_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= LINE_BYTES); // R10
endmodule

bind curs_overlay curs_overlay_chk #(
    .ADDR_W(ADDR_W), .XW(XW), .YW(YW), .CUR_DIM(CUR_DIM)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cur_en(cur_en), .vde(vde), .hdisp(hdisp),
    .mem_req(mem_req), .mem_addr(mem_addr), .pix_valid(pix_valid),
    .scan_x(scan_x), .scan_y(scan_y), .pix_in(pix_in), .pix_out(pix_out),
    .pix_out_valid(pix_out_valid)
);

// File: tb/curs_overlay_tb.sv
module curs_overlay_tb;
    localparam int ADDR_W = 27;
    localparam int XW = 14;
    localparam int YW = 12;
    localparam logic [ADDR_W-1:0] BASE = 27'h0004000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_we = 1'b0; logic [1:0] reg_sel = '0; logic [31:0] reg_wdata = '0;
    logic cur_en = 1'b0; logic [ADDR_W-1:0] base_off = BASE;
    logic [YW-1:0] vde = 12'd479; logic [XW-1:0] hdisp = 14'd640;
    logic line_start = 1'b0; logic [YW-1:0] line_y = '0;
    logic mem_req; logic [ADDR_W-1:0] mem_addr;
    logic mem_rvalid = 1'b0; logic [7:0] mem_rdata = '0;
    logic pix_valid = 1'b0; logic [XW-1:0] scan_x = '0; logic [YW-1:0] scan_y = '0;
    logic [31:0] pix_in = '0, pix_out; logic pix_out_valid;

    int errors = 0, checks = 0, cycles = 0, req_idx = 0;
    int m_px = 0, m_py = 0, m_poff = 0, m_lock = 0, m_ax = 0, m_ay = 0, m_aoff = 0;
    logic [23:0] m_c0 = '0, m_c1 = '0;
    logic [ADDR_W-1:0] exp_a0 = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    curs_overlay u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .cur_en(cur_en), .base_off(base_off), .vde(vde), .hdisp(hdisp),
        .line_start(line_start), .line_y(line_y), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pix_valid(pix_valid),
        .scan_x(scan_x), .scan_y(scan_y), .pix_in(pix_in), .pix_out(pix_out),
        .pix_out_valid(pix_out_valid)
    );

    function automatic logic [7:0] mbyte(logic [ADDR_W-1:0] a);
        logic [31:0] w = 32'(a);
        return 8'((w * 157) ^ (w >> 5) ^ 32'h3C);
    endfunction

    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mbyte(mem_addr);
    end

    task automatic check(bit ok, string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // R10: address sequence monitor
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            check(mem_addr == exp_a0 + ADDR_W'(req_idx), "R10 read address",
                  64'(mem_addr), 64'(exp_a0 + ADDR_W'(req_idx)));
            req_idx++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic bit line_hit(int y);
        return cur_en && y >= m_ay && y < m_ay + 64 && y <= int'(vde);
    endfunction

    function automatic logic [31:0] exp_pix(int x, int y, logic [31:0] pin, output string tag);
        int col, rel;
        logic [ADDR_W-1:0] la;
        logic [7:0] mb, pb;
        logic a, p;
        if (!cur_en || y < m_ay || y >= m_ay + 64) begin tag = "R5 outside"; return pin; end
        if (y > int'(vde)) begin tag = "R6 beyond vde"; return pin; end
        if (x < m_ax || x >= m_ax + 64) begin tag = "R5 outside"; return pin; end
        if (x >= int'(hdisp)) begin tag = "R7 clipped"; return pin; end
        rel = y - m_ay; col = x - m_ax;
        la = BASE + ADDR_W'(m_aoff) + ADDR_W'(rel * 16);
        mb = mbyte(la + ADDR_W'(col / 8));
        pb = mbyte(la + ADDR_W'(8 + col / 8));
        a = mb[7 - col % 8]; p = pb[7 - col % 8];
        if (a && p) begin tag = "R1 R2 invert"; return ~pin; end
        if (a) begin tag = "R1 R3 transparent"; return pin; end
        tag = p ? "R1 R4 colour1" : "R1 R4 colour0";
        return {p ? m_c1 : m_c0, 8'hFF};
    endfunction

    task automatic wr(logic [1:0] sel, logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
        case (sel)
            2'd0: begin m_px = int'(d[29:16]); m_py = int'(d[11:0]); m_lock = int'(d[31]); end
            2'd1: m_poff = int'(d[ADDR_W-1:0]) & ~32'hF;
            2'd2: m_c0 = d[23:0];
            default: m_c1 = d[23:0];
        endcase
        if (m_lock == 0) begin m_ax = m_px; m_ay = m_py; m_aoff = m_poff; end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_line(int y, int x0, int x1);
        bit hitl = line_hit(y);
        string tag;
        logic [31:0] e;
        exp_a0 = BASE + ADDR_W'(m_aoff) + ADDR_W'((y - m_ay) * 16);
        @(negedge clk); req_idx = 0; line_start = 1'b1; line_y = YW'(y);
        @(negedge clk); line_start = 1'b0;
        repeat (30) @(negedge clk);
        check(req_idx == (hitl ? 16 : 0), "R10 read count", 64'(req_idx), hitl ? 64'd16 : 64'd0);
        for (int x = x0; x <= x1; x++) begin
            scan_x = XW'(x); scan_y = YW'(y); pix_in = $urandom; pix_valid = 1'b1;
            e = exp_pix(x, y, pix_in, tag);
            @(negedge clk); pix_valid = 1'b0;
            check(pix_out_valid == 1'b1, "R11 valid latency", 64'(pix_out_valid), 64'd1);
            check(pix_out == e, tag, 64'(pix_out), 64'(e));
        end
        @(negedge clk);
        check(pix_out_valid == 1'b0, "R11 valid drop", 64'(pix_out_valid), 64'd0);
    endtask

    task automatic span(int y);
        int x0 = (m_ax > 3) ? m_ax - 3 : 0;
        run_line(y, x0, m_ax + 66);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pix_out_valid == 1'b0, "R11 reset valid", 64'(pix_out_valid), 64'd0);
        check(mem_req == 1'b0, "R10 reset request", 64'(mem_req), 64'd0);

        // R8: garbage outside the fields must be ignored
        wr(2'd2, 32'hAB12_3456);
        wr(2'd3, 32'hCD65_4321);
        wr(2'd1, 32'h0000_123F);
        wr(2'd0, 32'h4028_F014);
        cur_en = 1'b1;
        span(20);
        span(83);   // last cursor row
        span(84);   // R5 just below window
        span(19);   // R5 just above window

        // R7: cursor straddles right edge
        wr(2'd0, 32'h0258_001E);
        span(40);
        hdisp = 14'd300;
        wr(2'd0, 32'h00FA_001E);
        span(45);
        hdisp = 14'd640;

        // R6: vertical display end
        vde = 12'd35;
        span(35);
        span(36);
        vde = 12'd479;

        // R5: disabled
        cur_en = 1'b0;
        span(40);
        cur_en = 1'b1;

        // R9: locked update is held, unlock applies
        wr(2'd0, 32'h8064_0032);
        wr(2'd1, 32'h0000_2000);
        span(40);
        wr(2'd0, 32'h0064_0032);
        span(55);

        for (int i = 0; i < 20; i++) begin
            int cyv = $urandom_range(0, 400);
            int cxv = $urandom_range(0, 600);
            hdisp = 14'($urandom_range(64, 700));
            vde = 12'($urandom_range(200, 479));
            cur_en = ($urandom_range(0, 7) != 0);
            wr(2'd2, $urandom);
            wr(2'd3, $urandom);
            wr(2'd1, $urandom_range(0, 32'hFFFFF));
            wr(2'd0, {2'b00, 14'(cxv), 4'h0, 12'(cyv)});
            span(cyv + $urandom_range(0, 69) - 3 < 0 ? 0 : cyv + $urandom_range(0, 69) - 3);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule